// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of trace frames into an on-chip RAM that is used as a ring. A host sets the buffer up and reads it back through a small register port made of an address, a write strobe, a read strobe and 32-bit data. While capture is enabled, every valid frame is written at the write pointer, and the pointer advances modulo the depth. A sticky full flag records that the pointer has wrapped at least once. When full is clear, the valid frames are at addresses 0 up to the write pointer minus one. When full is set, the oldest frame is at the write pointer.

A trigger pulse arms a post-trigger countdown. After the trigger, each stored frame lowers the count. When the count runs out, acquisition-complete is set and storing stops without any host action. A demultiplexed input mode packs two half-width beats into one stored word. A staging register holds the first half until its partner arrives. The formatter-empty flag shows that this staging register is empty. A half left over when capture stops is written out padded with zeros. The host reads the stored words through a data register that advances the read pointer on every read.

Top module: `trc_capture_buf`

## Requirements
- R1: After reset, reg_rdata is 0, full_o and done_o are 0 and fmt_empty_o is 1. Register address 0 reads the identification constant ID_WORD (default 0x5EB00A11), address 1 reads the depth DEPTH and address 2 reads the frame width FRAME_W.
- R2: A frame is stored only while control bit 0 (enable, register address 8) is 1 and done_o is 0. Each stored frame goes to the write pointer, which then increments modulo DEPTH. The write pointer reads back at address 6.
- R3: full_o, which is status bit 0 at address 3, is set when a store takes the write pointer from DEPTH-1 to 0. It stays set until the write pointer is written, or until control bit 0 is written from 0 to 1. Either of those events also clears done_o and the trigger-seen flag.
- R4: The trigger counter is at address 7. A trigger pulse during active capture sets trigger-seen, which is status bit 2. From then on, each store decrements the counter. The store that takes it from 1 to 0 sets done_o, which is status bit 1, and later frames are not stored. The counter reads back its remaining value.
- R5: A trigger pulse while capture is not active leaves trigger-seen clear.
- R6: A read of address 4 returns the word at the read pointer, and the read pointer then increments modulo DEPTH. The read pointer is written and read at address 5.
- R7: Writing 0 to the control register stops capture, and frames that follow are not stored.
- R8: With control bit 1 set (demultiplexed mode), two consecutive valid beats form one stored word. The low 16 bits of the first beat become bits 15:0 and the low 16 bits of the second beat become bits 31:16.
- R9: fmt_empty_o, which is status bit 3, is 0 while a first half waits for its partner. If capture stops with a half pending, the half is stored with zero upper bits one cycle later, and fmt_empty_o returns to 1.
- R10: Writes to the identification, depth, width, status and data addresses have no effect. Addresses 9 to 15 read 0.
- R11: reg_rdata updates only on the clock edge that samples reg_rd, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Trace beat valid |
| frm_data | input | FRAME_W | Trace beat data |
| trig_in | input | 1 | Trigger pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| full_o | output | 1 | Sticky wrap flag |
| done_o | output | 1 | Acquisition complete |
| fmt_empty_o | output | 1 | No half-frame pending |

## Verification
The first pattern is a short run of frames that stops on a control write before the write pointer wraps. It separates the gating from the pointer arithmetic, because the last few frames must be missing. The second pattern is a run longer than the depth, read back starting at the write pointer. It shows whether the sticky full flag is set and whether read-pointer wrap puts the oldest word first. The third pattern places a trigger between frame bursts. It tests that exactly the programmed number of frames is stored after the trigger and that the counter is left at zero. The fourth pattern drives paired half beats with junk in the upper bits, followed by an odd beat. It checks the packing order, that the upper bits are dropped, and that the leftover half is flushed with zero padding.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int REG_AW = 4;
    localparam int REG_DW = 32;

    typedef enum logic [REG_AW-1:0] {
        REG_IDENT = 4'd0,
        REG_DEPTH = 4'd1,
        REG_WIDTH = 4'd2,
        REG_STAT  = 4'd3,
        REG_DATA  = 4'd4,
        REG_RPTR  = 4'd5,
        REG_WPTR  = 4'd6,
        REG_TCNT  = 4'd7,
        REG_CTRL  = 4'd8
    } reg_sel_e;

    localparam int CTL_EN    = 0;
    localparam int CTL_DEMUX = 1;

    typedef struct packed {
        logic fmt_empty;
        logic trig_seen;
        logic done;
        logic full;
    } stat_t;

    function automatic logic [REG_DW-1:0] pack_status(stat_t s);
        return {{(REG_DW-4){1'b0}}, s};
    endfunction

endpackage

// File: rtl/trc_ram.sv
module trc_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trc_ingest.sv
module trc_ingest #(
    parameter int FRAME_W = 32,
    localparam int HALF   = FRAME_W / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               demux,
    input  logic               frm_valid,
    input  logic [FRAME_W-1:0] frm_data,
    output logic               store,
    output logic [FRAME_W-1:0] word,
    output logic               pend
);
    logic [HALF-1:0] low_q;

    always_comb begin
        store = 1'b0;
        word  = frm_data;
        if (!demux) begin
            store = active & frm_valid;
        end else if (active && frm_valid && pend) begin
            store = 1'b1;
            word  = {frm_data[HALF-1:0], low_q};
        end else if (!active && pend) begin
            store = 1'b1;
            word  = {{HALF{1'b0}}, low_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            low_q <= '0;
        end else if (active && frm_valid && demux) begin
            if (!pend) begin
                low_q <= frm_data[HALF-1:0];
                pend  <= 1'b1;
            end else begin
                pend  <= 1'b0;
            end
        end else if (!active && pend) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
    parameter int DEPTH  = 16,
    parameter int TRIG_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_wptr,
    input  logic              wr_rptr,
    input  logic              wr_tcnt,
    input  logic [31:0]       wdata,
    input  logic              pop,
    input  logic              store,
    input  logic              trig_in,
    output logic              ctrl_en,
    output logic              demux,
    output logic              cap_active,
    output logic [AW-1:0]     wr_ptr,
    output logic [AW-1:0]     rd_ptr,
    output logic [TRIG_W-1:0] tcnt,
    output logic              full,
    output logic              done,
    output logic              trig_seen
);
    import trc_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic restart, trig_eff, cnt_store;

    assign cap_active = ctrl_en & ~done;
    assign restart    = (wr_ctrl & wdata[CTL_EN] & ~ctrl_en) | wr_wptr;
    assign trig_eff   = trig_seen | (trig_in & cap_active);
    assign cnt_store  = store & cap_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en   <= 1'b0;
            demux     <= 1'b0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            tcnt      <= '0;
            full      <= 1'b0;
            done      <= 1'b0;
            trig_seen <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en <= wdata[CTL_EN];
                demux   <= wdata[CTL_DEMUX];
            end

            if (wr_rptr)  rd_ptr <= wdata[AW-1:0];
            else if (pop) rd_ptr <= rd_ptr + 1'b1;

            if (wr_wptr)    wr_ptr <= wdata[AW-1:0];
            else if (store) wr_ptr <= wr_ptr + 1'b1;

            if (restart) begin
                full      <= 1'b0;
                done      <= 1'b0;
                trig_seen <= 1'b0;
            end else begin
                if (store && wr_ptr == LAST) full <= 1'b1;
                if (trig_in && cap_active) trig_seen <= 1'b1;
                if (trig_eff && cap_active &&
                    (tcnt == '0 || (cnt_store && tcnt == TRIG_W'(1))))
                    done <= 1'b1;
            end

            if (wr_tcnt)
                tcnt <= wdata[TRIG_W-1:0];
            else if (trig_eff && cnt_store && tcnt != '0)
                tcnt <= tcnt - 1'b1;
        end
    end
endmodule

// File: rtl/trc_capture_buf.sv
module trc_capture_buf #(
    parameter int          DEPTH   = 16,
    parameter int          FRAME_W = 32,
    parameter int          TRIG_W  = 16,
    parameter logic [31:0] ID_WORD = 32'h5EB0_0A11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frm_valid,
    input  logic [FRAME_W-1:0] frm_data,
    input  logic               trig_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               full_o,
    output logic               done_o,
    output logic               fmt_empty_o
);
    import trc_pkg::*;

    localparam int ADDR_W = $clog2(DEPTH);

    logic               ctrl_en, demux, cap_active, trig_seen;
    logic               store, pend, full_q, done_q;
    logic [FRAME_W-1:0] st_word, ram_q;
    logic [ADDR_W-1:0]  wr_ptr, rd_ptr;
    logic [TRIG_W-1:0]  tcnt;
    logic               wr_ctrl, wr_wptr, wr_rptr, wr_tcnt, pop;
    reg_sel_e           sel;
    stat_t              stat;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_ctrl = reg_wr && sel == REG_CTRL;
    assign wr_wptr = reg_wr && sel == REG_WPTR;
    assign wr_rptr = reg_wr && sel == REG_RPTR;
    assign wr_tcnt = reg_wr && sel == REG_TCNT;
    assign pop     = reg_rd && sel == REG_DATA;

    trc_ingest #(.FRAME_W(FRAME_W)) u_ingest (
        .clk(clk), .rst(rst), .active(cap_active), .demux(demux),
        .frm_valid(frm_valid), .frm_data(frm_data),
        .store(store), .word(st_word), .pend(pend)
    );

    trc_ctrl #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_wptr(wr_wptr),
        .wr_rptr(wr_rptr), .wr_tcnt(wr_tcnt), .wdata(reg_wdata),
        .pop(pop), .store(store), .trig_in(trig_in),
        .ctrl_en(ctrl_en), .demux(demux), .cap_active(cap_active),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .tcnt(tcnt),
        .full(full_q), .done(done_q), .trig_seen(trig_seen)
    );

    trc_ram #(.DEPTH(DEPTH), .W(FRAME_W)) u_ram (
        .clk(clk), .we(store), .waddr(wr_ptr), .wdata(st_word),
        .raddr(rd_ptr), .rdata(ram_q)
    );

    assign stat = '{fmt_empty: ~pend, trig_seen: trig_seen,
                    done: done_q, full: full_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (sel)
                REG_IDENT: reg_rdata <= ID_WORD;
                REG_DEPTH: reg_rdata <= 32'(DEPTH);
                REG_WIDTH: reg_rdata <= 32'(FRAME_W);
                REG_STAT:  reg_rdata <= pack_status(stat);
                REG_DATA:  reg_rdata <= 32'(ram_q);
                REG_RPTR:  reg_rdata <= 32'(rd_ptr);
                REG_WPTR:  reg_rdata <= 32'(wr_ptr);
                REG_TCNT:  reg_rdata <= 32'(tcnt);
                REG_CTRL:  reg_rdata <= {30'b0, demux, ctrl_en};
                default:   reg_rdata <= '0;
            endcase
        end
    end

    assign full_o      = full_q;
    assign done_o      = done_q;
    assign fmt_empty_o = ~pend;
endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_rdata,
    input logic          full_o,
    input logic          done_o,
    input logic          fmt_empty_o,
    input logic [AW-1:0] wp,
    input logic [AW-1:0] rp,
    input logic          trig_seen,
    input logic          cap_active,
    input logic          ctrl_en
);
    p_full_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(full_o) |-> $past(reg_wr))
        else $error("full cleared without host write");

    p_done_halts_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && fmt_empty_o && !reg_wr) |=> $stable(wp))
        else $error("store after acquisition complete");

    p_idle_no_store_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && fmt_empty_o && !reg_wr) |=> $stable(wp))
        else $error("store while disabled");

    p_trig_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (!cap_active && !trig_seen) |=> !trig_seen)
        else $error("trigger accepted while inactive");

    p_rptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 4'd4) |=> (rp == AW'($past(rp) + 1'b1)))
        else $error("read pointer did not advance");

    p_drain_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> fmt_empty_o)
        else $error("half frame left after completion");

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata))
        else $error("read data changed without read");
endmodule

bind trc_capture_buf trc_capture_chk #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .full_o(full_o),
    .done_o(done_o), .fmt_empty_o(fmt_empty_o), .wp(wr_ptr),
    .rp(rd_ptr), .trig_seen(trig_seen), .cap_active(cap_active),
    .ctrl_en(ctrl_en)
);

// File: tb/tb_trc_capture_buf.sv
module tb_trc_capture_buf;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [31:0] frm_data = '0;
    logic        trig_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        full_o, done_o, fmt_empty_o;

    int errors = 0;
    int checks = 0;

    trc_capture_buf #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
        .trig_in(trig_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .full_o(full_o), .done_o(done_o), .fmt_empty_o(fmt_empty_o)
    );

    always #10 clk = ~clk;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_d = 1'b0;

    always @(posedge clk) rd_d <= reg_rd;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, reg_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic frames(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frm_valid = 1'b1; frm_data = base + 32'(i);
        end
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic beat(input logic [31:0] d);
        @(negedge clk);
        frm_valid = 1'b1; frm_data = d;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic pulse_trig;
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 full", {31'b0, full_o}, 32'h0);
        check("R1 done", {31'b0, done_o}, 32'h0);
        check("R1 fmt_empty", {31'b0, fmt_empty_o}, 32'h1);
        rd(4'd0, 32'h5EB0_0A11, "R1 ident");
        rd(4'd1, 32'd16, "R1 depth");
        rd(4'd2, 32'd32, "R1 width");
        rd(4'd3, 32'h8, "R1 status");

        // R2 and R7: short capture, stopped before wrap
        wr(4'd7, 32'd100);
        wr(4'd6, 32'd0);
        wr(4'd8, 32'h1);
        frames(5, 32'hA000_0000);
        wr(4'd8, 32'h0);
        frames(2, 32'hEEEE_0000);
        rd(4'd6, 32'd5, "R7 wptr after stop");
        rd(4'd3, 32'h8, "R2 status no wrap");
        wr(4'd5, 32'd0);
        for (int i = 0; i < 5; i++) rd(4'd4, 32'hA000_0000 + 32'(i), "R2/R6 data");
        rd(4'd5, 32'd5, "R6 rptr advanced");

        // R5: trigger ignored while inactive
        pulse_trig();
        rd(4'd3, 32'h8, "R5 status after idle trigger");

        // R10: read-only writes and unused addresses
        wr(4'd0, 32'h1234_5678);
        wr(4'd1, 32'h7);
        wr(4'd3, 32'hF);
        rd(4'd0, 32'h5EB0_0A11, "R10 ident unchanged");
        rd(4'd1, 32'd16, "R10 depth unchanged");
        rd(4'd3, 32'h8, "R10 status unchanged");
        rd(4'd15, 32'h0, "R10 unused address");
        @(negedge clk);
        check("R11 rdata held", reg_rdata, 32'h0);

        // R3 and R6: wrap, oldest at the write pointer
        wr(4'd6, 32'd0);
        wr(4'd8, 32'h1);
        frames(20, 32'hB000_0000);
        wr(4'd8, 32'h0);
        @(negedge clk);
        check("R3 full set", {31'b0, full_o}, 32'h1);
        rd(4'd6, 32'd4, "R3 wptr after wrap");
        rd(4'd3, 32'h9, "R3 status");
        wr(4'd5, 32'd4);
        for (int k = 0; k < DEPTH; k++) begin
            int a;
            int idx;
            a = (4 + k) % DEPTH;
            idx = (a < 4) ? a + DEPTH : a;
            rd(4'd4, 32'hB000_0000 + 32'(idx), "R3/R6 ring order");
        end
        rd(4'd5, 32'd4, "R6 rptr wrapped");
        wr(4'd6, 32'd0);
        @(negedge clk);
        check("R3 full cleared", {31'b0, full_o}, 32'h0);

        // R4: post-trigger countdown
        wr(4'd7, 32'd3);
        wr(4'd6, 32'd0);
        wr(4'd8, 32'h1);
        frames(2, 32'hC000_0000);
        pulse_trig();
        frames(5, 32'hC000_0010);
        @(negedge clk);
        check("R4 done", {31'b0, done_o}, 32'h1);
        rd(4'd6, 32'd5, "R4 stored count");
        rd(4'd7, 32'd0, "R4 counter remaining");
        rd(4'd3, 32'hE, "R4 status");
        wr(4'd5, 32'd2);
        rd(4'd4, 32'hC000_0010, "R4 first post-trigger");
        wr(4'd5, 32'd4);
        rd(4'd4, 32'hC000_0012, "R4 last post-trigger");
        wr(4'd8, 32'h0);
        wr(4'd8, 32'h1);
        @(negedge clk);
        check("R3 done cleared on re-enable", {31'b0, done_o}, 32'h0);
        wr(4'd8, 32'h0);

        // R8 and R9: demultiplexed packing and drain
        wr(4'd6, 32'd0);
        wr(4'd8, 32'h3);
        beat(32'hDEAD_1111);
        check("R9 half pending", {31'b0, fmt_empty_o}, 32'h0);
        beat(32'hBEEF_2222);
        check("R9 pair stored", {31'b0, fmt_empty_o}, 32'h1);
        beat(32'hCAFE_3333);
        check("R9 odd half pending", {31'b0, fmt_empty_o}, 32'h0);
        wr(4'd8, 32'h2);
        @(negedge clk);
        check("R9 drained", {31'b0, fmt_empty_o}, 32'h1);
        rd(4'd6, 32'd2, "R9 wptr after flush");
        wr(4'd5, 32'd0);
        rd(4'd4, 32'h2222_1111, "R8 packed word");
        rd(4'd4, 32'h0000_3333, "R9 flushed half");

        repeat (4) @(negedge clk);
        check("scoreboard empty", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule